// File: doc/BRIEF.md
# Leading-Zero Normalized Iterative Divider

This block is an iterative integer divider for the four integer divide and remainder operations: signed and unsigned quotient, and signed and unsigned remainder. A single start strobe captures the dividend, divisor and operation. The block then holds `busy_o` while it works, and `done_o` marks the one cycle in which a fresh `result_o` is presented. The execute stage that owns the divider stalls for as long as `busy_o` is high.

The latency depends on the divisor. When the operands are captured, the block counts the leading zeros of the divisor magnitude and aligns the divisor so that its top set bit sits at the most significant position. It then runs only the restoring shift-subtract steps that can yield a nonzero quotient bit. A divisor with its top bit set finishes in the fewest cycles, and a zero divisor takes the most. Sign fixup and the results for the special cases are folded into the last iteration. The operation itself never needs a separate correction cycle.

Top module: `lz_divider`

## Requirements
- R1: `op_i` selects the operation: 2'b00 signed quotient, 2'b01 unsigned quotient, 2'b10 signed remainder, 2'b11 unsigned remainder. For 2'b01 and a nonzero divisor, `result_o` is floor(dividend / divisor) with both operands taken as unsigned.
- R2: For 2'b00 and a nonzero divisor (other than the overflow case of R7), the quotient is rounded toward zero. Its magnitude is |a| / |b|, and it is negative when the operand signs differ.
- R3: For 2'b10 and 2'b11 with a nonzero divisor, the remainder satisfies a = q*b + r. For the signed operation the remainder takes the sign of the dividend.
- R4: Count the cycle in which an accepted start is presented as cycle 1. `done_o` is then high in cycle 3 + clz(m), where m is the divisor for the unsigned operations and |divisor| for the signed ones, and clz(0) = 32.
- R5: A divisor magnitude with bit 31 set (0x80000000 unsigned, or -2^31 signed) gives the minimum latency of 3 cycles.
- R6: A zero divisor takes 35 cycles. It returns a quotient of 0xFFFFFFFF and a remainder equal to the dividend, for both signed and unsigned operations.
- R7: Signed -2^31 / -1 returns a quotient of 0x80000000 and a remainder of 0, after 34 cycles.
- R8: `busy_o` is high from the cycle after an accepted start up to and including the `done_o` cycle, and low at all other times. `done_o` lasts exactly one cycle.
- R9: The block accepts `start_i` only while `busy_o` is low. Changes to the operands or to `op_i` while busy, and any start while busy (the done cycle included), do not affect the result or the timing.
- R10: After reset `busy_o`, `done_o` and `result_o` are 0. `result_o` holds its value between `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted when `busy_o` is low |
| op_i | input | 2 | Operation select (bit 1: remainder, bit 0: unsigned) |
| dividend_i | input | 32 | Dividend, captured on an accepted start |
| divisor_i | input | 32 | Divisor, captured on an accepted start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse; `result_o` is valid |
| result_o | output | 32 | Quotient or remainder, held until the next completion |

## Verification
Directed operands cover each sign combination for both the quotient and the remainder. Together they separate truncation toward zero from floor rounding, and show that the remainder follows the dividend's sign and not the divisor's. Divisors of zero, one, 0x80000000 and -2^31 mark the extreme latencies and the overflow result. Random operands use divisors shifted right by a random amount, so every leading-zero count from 0 to 32 occurs. Each of these counts pins the completion cycle against the model's count. Some runs hold start high and scramble the operands throughout the busy window, which separates captured operands from live ones and shows whether a start during the done cycle is wrongly accepted.

// File: rtl/lzdiv_pkg.sv
package lzdiv_pkg;

  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } div_state_e;

endpackage

// File: rtl/lzdiv_clz.sv
module lzdiv_clz #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] count_o,
  output logic          zero_o
);

  // scan upward so the highest set bit wins
  always_comb begin
    count_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) count_o = CW'(W - 1 - i);
    end
  end

  assign zero_o = (val_i == '0);

endmodule

// File: rtl/lzdiv_magnitude.sv
module lzdiv_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         signed_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);

  assign neg_o = signed_i & val_i[W-1];
  assign mag_o = neg_o ? (~val_i + 1'b1) : val_i;

endmodule

// File: rtl/lzdiv_step.sv
module lzdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dvs_i,
  input  logic [W-1:0] quo_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dvs_o,
  output logic [W-1:0] quo_o
);

  logic fits;

  assign fits  = (rem_i >= dvs_i);
  assign rem_o = fits ? (rem_i - dvs_i) : rem_i;
  assign quo_o = {quo_i[W-2:0], fits};
  assign dvs_o = dvs_i >> 1;

endmodule

// File: rtl/lz_divider.sv
module lz_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);

  import lzdiv_pkg::*;

  localparam int CNT_W = $clog2(WIDTH + 1);

  div_state_e       state_q;
  logic [WIDTH-1:0] rem_q, dvs_q, quo_q, result_q;
  logic [CNT_W-1:0] iter_q;
  logic             neg_quo_q, neg_rem_q, is_rem_q;

  logic             accept, op_signed;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic             sgn_a, sgn_b, b_zero;
  logic [CNT_W-1:0] lz_b;
  logic [WIDTH-1:0] rem_n, dvs_n, quo_n, quo_fix, rem_fix;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign op_signed = ~op_i[0];

  lzdiv_magnitude #(.W(WIDTH)) i_mag_a (
    .val_i    (dividend_i),
    .signed_i (op_signed),
    .mag_o    (mag_a),
    .neg_o    (sgn_a)
  );

  lzdiv_magnitude #(.W(WIDTH)) i_mag_b (
    .val_i    (divisor_i),
    .signed_i (op_signed),
    .mag_o    (mag_b),
    .neg_o    (sgn_b)
  );

  lzdiv_clz #(.W(WIDTH), .CW(CNT_W)) i_clz (
    .val_i   (mag_b),
    .count_o (lz_b),
    .zero_o  (b_zero)
  );

  lzdiv_step #(.W(WIDTH)) i_step (
    .rem_i (rem_q),
    .dvs_i (dvs_q),
    .quo_i (quo_q),
    .rem_o (rem_n),
    .dvs_o (dvs_n),
    .quo_o (quo_n)
  );

  // zero divisor: iterations yield all ones and |a|; quotient sign is masked
  assign quo_fix = neg_quo_q ? (~quo_n + 1'b1) : quo_n;
  assign rem_fix = neg_rem_q ? (~rem_n + 1'b1) : rem_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      dvs_q     <= '0;
      quo_q     <= '0;
      iter_q    <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      is_rem_q  <= 1'b0;
      result_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            rem_q     <= mag_a;
            dvs_q     <= mag_b << lz_b;
            quo_q     <= '0;
            iter_q    <= lz_b;
            neg_quo_q <= (sgn_a ^ sgn_b) & ~b_zero;
            neg_rem_q <= sgn_a;
            is_rem_q  <= op_i[1];
            state_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q  <= rem_n;
          dvs_q  <= dvs_n;
          quo_q  <= quo_n;
          iter_q <= iter_q - CNT_W'(1);
          if (iter_q == '0) begin
            result_q <= is_rem_q ? rem_fix : quo_fix;
            state_q  <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign result_o = result_q;

endmodule

// File: rtl/lzdiv_checker.sv
module lzdiv_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o
);

  function automatic int lead_zeros(input logic [WIDTH-1:0] v);
    int n;
    n = 0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (v[i]) break;
      n++;
    end
    return n;
  endfunction

  logic [7:0]       cyc_q, lat_q;
  logic             zero_q, rem_op_q;
  logic [WIDTH-1:0] mag;

  assign mag = (!op_i[0] && divisor_i[WIDTH-1]) ? (~divisor_i + 1'b1) : divisor_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q    <= '0;
      lat_q    <= '0;
      zero_q   <= 1'b0;
      rem_op_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      cyc_q    <= 8'd2;
      lat_q    <= 8'(3 + lead_zeros(mag));
      zero_q   <= (divisor_i == '0);
      rem_op_q <= op_i[1];
    end else if (busy_o) begin
      cyc_q <= cyc_q + 8'd1;
    end
  end

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_q == lat_q));

  a_r4_no_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cyc_q < lat_q) |-> !done_o);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r8_busy_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r9_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  a_r6_zero_quotient: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zero_q && !rem_op_q) |-> (result_o == '1));

endmodule

bind lz_divider lzdiv_checker #(.WIDTH(WIDTH)) i_lzdiv_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .op_i       (op_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/test_lz_divider.sv
`timescale 1ns/1ps
module test_lz_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] result;

  always #4 clk = ~clk;

  lz_divider i_lz_divider (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .op_i       (op),
    .dividend_i (a),
    .divisor_i  (b),
    .busy_o     (busy),
    .done_o     (done),
    .result_o   (result)
  );

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  bit          exp_busy = 0, exp_done = 0, glitch_next = 0;
  logic [31:0] exp_result = '0, pending = '0;
  int          wait_n = 0, lat = 0;
  string       res_tag = "R1", done_tag = "R4";

  function automatic logic [31:0] ref_result(input logic [1:0] o, input logic [31:0] x,
                                              input logic [31:0] y);
    logic [31:0] q, r;
    if (y == 0) begin
      q = '1; r = x;
    end else if (!o[0] && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) begin
      q = x; r = 0;
    end else if (!o[0]) begin
      q = $signed(x) / $signed(y); r = $signed(x) % $signed(y);
    end else begin
      q = x / y; r = x % y;
    end
    return o[1] ? r : q;
  endfunction

  function automatic int ref_latency(input logic [1:0] o, input logic [31:0] y);
    logic [31:0] m;
    int z;
    m = (!o[0] && y[31]) ? -y : y;
    z = 32;
    for (int i = 0; i < 32; i++) if (m[i]) z = 31 - i;
    return 3 + z;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_busy = 0; exp_done = 0; exp_result = '0; wait_n = 0;
    end else if (exp_done) begin
      exp_done = 0; exp_busy = 0;
    end else if (exp_busy) begin
      wait_n--;
      if (wait_n == 0) begin
        exp_done = 1; exp_result = pending;
      end
    end else if (start) begin
      pending  = ref_result(op, a, b);
      lat      = ref_latency(op, b);
      done_tag = (lat == 3) ? "R5" : "R4";
      if (glitch_next) res_tag = "R9";
      else if (b == 0) res_tag = "R6";
      else if (!op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) res_tag = "R7";
      else if (op[1]) res_tag = "R3";
      else if (!op[0]) res_tag = "R2";
      else res_tag = "R1";
      exp_busy = 1; wait_n = lat - 2;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, expv, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R8 busy", {31'b0, busy}, {31'b0, exp_busy});
      check(done_tag, {31'b0, done}, {31'b0, exp_done});
      check(exp_done ? res_tag : "R10", result, exp_result);
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                        input bit glitch);
    @(negedge clk);
    glitch_next = glitch;
    start = 1; op = o; a = x; b = y;
    @(negedge clk);
    if (!glitch) begin
      start = 0;
      while (exp_busy) @(negedge clk);
    end else begin
      while (!exp_done) begin
        a = $urandom; b = $urandom; op = 2'($urandom);
        @(negedge clk);
      end
      start = 0;
      @(negedge clk);
    end
    glitch_next = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset busy", {31'b0, busy}, 32'd0);
    check("R10 reset done", {31'b0, done}, 32'd0);
    check("R10 reset result", result, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_op(2'b01, 32'd100, 32'd7, 0);                    // R1
    run_op(2'b01, 32'hFFFF_FFFF, 32'h8000_0000, 0);      // R5 unsigned
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0);      // R5 signed
    run_op(2'b00, -32'sd7, 32'd2, 0);                    // R2
    run_op(2'b00, 32'd7, -32'sd2, 0);                    // R2
    run_op(2'b00, -32'sd7, -32'sd2, 0);                  // R2
    run_op(2'b10, -32'sd7, 32'd2, 0);                    // R3
    run_op(2'b10, 32'd7, -32'sd2, 0);                    // R3
    run_op(2'b11, 32'd100, 32'd7, 0);                    // R3
    run_op(2'b00, 32'd1234, 32'd0, 0);                   // R6
    run_op(2'b01, 32'hDEAD_BEEF, 32'd0, 0);              // R6
    run_op(2'b10, -32'sd55, 32'd0, 0);                   // R6
    run_op(2'b11, 32'hCAFE_0001, 32'd0, 0);              // R6
    run_op(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0);      // R7
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);      // R7
    run_op(2'b01, 32'h1234_5678, 32'd1, 0);              // R4 clz 31
    run_op(2'b00, 32'd999, 32'd3, 1);                    // R9
    run_op(2'b11, 32'hFFFF_0000, 32'd0, 1);              // R9

    for (int k = 0; k < 500; k++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom >> ($urandom % 33);
      run_op(2'($urandom), x, y, (k % 10) == 9);
    end

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule